// File: doc/BRIEF.md
# Two-Requester Priority Grant Arbiter

This block decides, once per clock, which of two requesters owns a shared resource. The high-priority requester always wins. Once it is granted, its grant stays up for a fixed hold window of two cycles, even if its request was only a one-cycle pulse. The low-priority grant is the default. It is given whenever the high-priority side neither requests nor holds a grant, whether or not the low-priority side is asking.

A small down-counter tracks how long the high-priority hold still has to run. Any new high-priority request reloads the counter to the full window. Both grants come from flip-flops, so no path runs from a request pin to a grant pin within a cycle.

Top module: `arb_prio2`

## Requirements
- R1: When both `req_hi` and `req_lo` are high in cycle t, `gnt_hi` is high and `gnt_lo` is low in cycle t+1.
- R2: When `req_hi` is high in cycle t, `gnt_hi` is high in both cycle t+1 and cycle t+2, including when `req_hi` was a single-cycle pulse.
- R3: When `req_hi` is low in cycle t and no hold is running (`gnt_hi` low in cycle t), `gnt_lo` is high in cycle t+1.
- R4: `gnt_hi` and `gnt_lo` are never high in the same cycle.
- R5: `req_lo` has no effect on either grant: any two input sequences that differ only in `req_lo` produce the same grants.
- R6: A `req_hi` that arrives while a hold is running reloads the window, so `gnt_hi` stays high through two cycles after the latest `req_hi`.
- R7: With `rst` high at a clock edge, both grants are low after that edge and any running hold is discarded. The first edge after `rst` falls follows R2 and R3 alone.
- R8: Once one clock edge has passed with `rst` low, exactly one of the two grants is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_hi | input | 1 | High-priority request |
| req_lo | input | 1 | Low-priority request |
| gnt_hi | output | 1 | Registered grant to the high-priority requester |
| gnt_lo | output | 1 | Registered grant to the low-priority requester, also the idle default |

## Verification
The bench targets four cases.

- **One-cycle pulse on `req_hi` with nothing behind it.** A design without the hold would drop `gnt_hi` after one cycle and raise `gnt_lo` too early.
- **`req_hi` repeated in the middle of a hold.** A design that does not reload the counter would release the grant one cycle early.
- **Idle cycles with `req_lo` high and with it low.** A design that treats `gnt_lo` as a reply to `req_lo` would leave both grants low.
- **Reset in the middle of a hold.** A design that keeps the counter through reset would give `gnt_hi` again after reset with no new request.

// File: rtl/arb_prio2_pkg.sv
package arb_prio2_pkg;

    typedef struct packed {
        logic hi;
        logic lo;
    } grant_t;

    localparam grant_t GRANT_NONE = '{hi: 1'b0, lo: 1'b0};

    // Pick the grant pair from the hold count that will be live next cycle.
    function automatic grant_t grant_from_hold(input logic hold_active);
        grant_t g;
        g.hi = hold_active;
        g.lo = ~hold_active;
        return g;
    endfunction

endpackage

// File: rtl/arb_hold_ctr.sv
module arb_hold_ctr #(
    parameter int HOLD_CYCLES = 2,
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic active_next
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(HOLD_CYCLES);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        if (load)
            cnt_d = FULL;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign active_next = (cnt_d != '0);
endmodule

// File: rtl/arb_grant_reg.sv
module arb_grant_reg
    import arb_prio2_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  grant_t grant_d,
    output grant_t grant_q
);
    always_ff @(posedge clk) begin
        if (rst)
            grant_q <= GRANT_NONE;
        else
            grant_q <= grant_d;
    end
endmodule

// File: rtl/arb_prio2.sv
module arb_prio2
    import arb_prio2_pkg::*;
#(
    parameter int HOLD_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_hi,
    input  logic req_lo,
    output logic gnt_hi,
    output logic gnt_lo
);
    logic   hold_next;
    grant_t grant_d;
    grant_t grant_q;
    logic   lo_unused;

    // The low request never steers the choice: the low grant is the idle default.
    assign lo_unused = req_lo;

    arb_hold_ctr #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk         (clk),
        .rst         (rst),
        .load        (req_hi),
        .active_next (hold_next)
    );

    assign grant_d = grant_from_hold(hold_next);

    arb_grant_reg u_greg (
        .clk     (clk),
        .rst     (rst),
        .grant_d (grant_d),
        .grant_q (grant_q)
    );

    assign gnt_hi = grant_q.hi;
    assign gnt_lo = grant_q.lo;
endmodule

// File: rtl/arb_prio2_chk.sv
module arb_prio2_chk (
    input logic clk,
    input logic rst,
    input logic req_hi,
    input logic req_lo,
    input logic gnt_hi,
    input logic gnt_lo
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= 2'd0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    // R1
    both_req_hi_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (req_hi && req_lo) |=> (gnt_hi && !gnt_lo));

    // R2
    hi_grant_next_chk: assert property (@(posedge clk) disable iff (rst)
        req_hi |=> gnt_hi);

    // R2
    hi_grant_second_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && $past(req_hi, 2)) |-> gnt_hi);

    // R3
    idle_default_chk: assert property (@(posedge clk) disable iff (rst)
        (!req_hi && !gnt_hi) |=> gnt_lo);

    // R4
    grants_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(gnt_hi && gnt_lo));

    // R7
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!gnt_hi && !gnt_lo));

    // R8
    one_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst != 2'd0) |-> $countones({gnt_hi, gnt_lo}) == 1);

    logic lo_seen;
    assign lo_seen = req_lo;
endmodule

bind arb_prio2 arb_prio2_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .req_hi (req_hi),
    .req_lo (req_lo),
    .gnt_hi (gnt_hi),
    .gnt_lo (gnt_lo)
);

// File: tb/sim_arb_prio2.sv
`timescale 1ns/1ps
module sim_arb_prio2;
    logic clk = 1'b0;
    logic rst;
    logic req_hi;
    logic req_lo;
    logic gnt_hi;
    logic gnt_lo;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    arb_prio2 u0 (
        .clk    (clk),
        .rst    (rst),
        .req_hi (req_hi),
        .req_lo (req_lo),
        .gnt_hi (gnt_hi),
        .gnt_lo (gnt_lo)
    );

    // {req_hi, req_lo, expected gnt_hi, expected gnt_lo} after the edge
    localparam int NV = 15;
    localparam logic [3:0] VEC [0:NV-1] = '{
        4'b0001, // R3 idle, no request
        4'b0101, // R5 low request alone, same grant as idle
        4'b1010, // R2 one-cycle pulse, first hold cycle
        4'b0010, // R2 second hold cycle overrides idle
        4'b0101, // R3 hold finished
        4'b1110, // R1 both requests
        4'b1010, // R6 repeat
        4'b0110, // R6 reloaded hold
        4'b0101, // R3
        4'b1010, // R2
        4'b0010, // R2
        4'b1010, // R6 reload in second hold cycle
        4'b0010, // R6
        4'b0001, // R3
        4'b0001  // R8
    };

    task automatic check(input string req, input logic eh, input logic el);
        checks++;
        if (gnt_hi !== eh || gnt_lo !== el) begin
            fails++;
            $display("FAIL %s: got hi=%b lo=%b expected hi=%b lo=%b",
                     req, gnt_hi, gnt_lo, eh, el);
        end
    endtask

    task automatic step(input logic h, input logic l);
        @(negedge clk);
        req_hi = h;
        req_lo = l;
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; req_hi = 1'b1; req_lo = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R7", 1'b0, 1'b0);
        rst = 1'b0; req_hi = 1'b0;

        for (int i = 0; i < NV; i++) begin
            req_hi = VEC[i][3];
            req_lo = VEC[i][2];
            @(negedge clk);
            check($sformatf("R1-table vec %0d", i), VEC[i][1], VEC[i][0]);
        end

        // R7: reset in the middle of a hold discards it
        req_hi = 1'b1; req_lo = 1'b0;
        @(negedge clk);
        check("R2", 1'b1, 1'b0);
        rst = 1'b1; req_hi = 1'b0;
        @(negedge clk);
        check("R7", 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R7", 1'b0, 1'b1);

        // R5: low request held high while high pulses, matches earlier pattern
        req_hi = 1'b1; req_lo = 1'b1;
        @(negedge clk);
        check("R5", 1'b1, 1'b0);
        req_hi = 1'b0;
        @(negedge clk);
        check("R5", 1'b1, 1'b0);
        @(negedge clk);
        check("R5", 1'b0, 1'b1);

        // R4 and R8: long request, then idle
        req_hi = 1'b1; req_lo = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R4", 1'b1, 1'b0);
        end
        req_hi = 1'b0;
        @(negedge clk);
        check("R2", 1'b1, 1'b0);
        @(negedge clk);
        check("R8", 1'b0, 1'b1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule